// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the network-layer controller of a slave on a single-wire, open-drain bus. A bit-level timeslot engine below it turns bus slots into one-cycle `bit_valid` strobes carrying `bit_in`, and reads `tx_req`/`tx_bit` when the master reads a bit. The block also samples the bus level itself. A low level held for too long counts as a bus reset from any state. After the line returns high, the block answers with a presence pulse on its open-drain output `drv_n`.

Once presence has finished, the block takes an 8-bit ROM command. Code 0x33 streams out its 64-bit identity. Code 0x55 compares 64 incoming bits against that identity. A full identity transfer raises `selected`, which hands the bus to a memory-command layer above. A mismatch or an unknown code sends the block into a silent state that only a new bus reset ends.

Top module: `owr_rom_layer`

## Requirements
- R1: After `rst_n` deasserts, `selected` and `tx_req` are 0 and `drv_n` is 1. No strobed bit has any effect until a bus reset and presence have completed.
- R2: The line held low for more than `RST_CYC` clock cycles is a bus reset in every state. It clears `selected` and `tx_req` while the line is still low. A low shorter than `RST_CYC` cycles changes nothing.
- R3: `PRES_GAP` cycles after the line returns high from a bus reset, `drv_n` goes low for exactly `PRES_CYC` cycles.
- R4: The command is the 8 bits strobed after presence, received least-significant bit first. For example, the stream 1,0,1,0,1,0,1,0 is 0x55.
- R5: After command 0x33, `tx_req` is 1 and `tx_bit` carries identity bit i for the i-th read slot, i = 0..63. The identity is laid out as bits [7:0] family code, [55:8] serial number and [63:56] CRC. Each strobe advances one bit, and the 64th strobe raises `selected`.
- R6: After command 0x55, 64 strobed bits are compared with identity bits 0..63 in order. If all 64 are equal, `selected` rises after the 64th strobe.
- R7: On the first compare mismatch the block falls silent. `selected` and `tx_req` stay 0, and every further strobe is ignored until the next bus reset.
- R8: Any command code other than 0x33 and 0x55, including the bit-reversed 0xAA, leads to the same silent state as R7.
- R9: `drv_n` is 0 only during the presence pulse. The block never drives a data value onto the line itself.
- R10: While `selected` is 1, strobed bits are ignored and `selected` holds until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Synchronized bus level (1 = released) |
| bit_valid | input | 1 | One-cycle strobe: a slot completed |
| bit_in | input | 1 | Bit value of the completed slot |
| tx_req | output | 1 | Block is sourcing read-slot data |
| tx_bit | output | 1 | Bit to send in the current read slot |
| selected | output | 1 | Identity addressed; memory layer may proceed |
| drv_n | output | 1 | Open-drain pull, 0 = pull line low |

## Verification
A stuck or wrong state shows up at the ports within one slot. It appears as a wrong `tx_bit` in the read sequence, as `selected` rising early or not at all after the 64th compare strobe, or as a presence pulse whose length differs from `PRES_CYC`. A reset detector that fails to abandon a transaction leaves `tx_req` or `selected` high after the line has been low past the threshold. The checker catches that within two cycles of the threshold. A mismatch that does not silence the block shows up as `selected` rising at the end of a corrupted match.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ_ID  = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH_ID = 8'h55;

    typedef enum logic [2:0] {
        ST_SILENT = 3'd0,
        ST_RSTLOW = 3'd1,
        ST_GAP    = 3'd2,
        ST_PRES   = 3'd3,
        ST_CMD    = 3'd4,
        ST_SEND   = 3'd5,
        ST_MATCH  = 3'd6,
        ST_SEL    = 3'd7
    } owr_state_e;

endpackage

// File: rtl/owr_low_timer.sv
module owr_low_timer #(
    parameter int RST_CYC = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic long_low
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (line_in) begin
            cnt_d = '0;
        end else if (cnt_q != CW'(RST_CYC)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // low has outlasted the threshold
    assign long_low = !line_in && (cnt_q == CW'(RST_CYC));

endmodule

// File: rtl/owr_id_cmp.sv
module owr_id_cmp #(
    parameter int              ID_W  = 64,
    parameter logic [ID_W-1:0] ROM_ID = '0,
    localparam int             IW    = $clog2(ID_W)
) (
    input  logic [IW-1:0] idx,
    input  logic          bit_in,
    output logic          ref_bit,
    output logic          eq
);
    assign ref_bit = ROM_ID[idx];
    assign eq      = (bit_in == ref_bit);
endmodule

// File: rtl/owr_rom_fsm.sv
module owr_rom_fsm
    import owr_rom_pkg::*;
#(
    parameter int PRES_GAP = 1000,
    parameter int PRES_CYC = 4000,
    parameter int ID_W     = 64,
    localparam int IW      = $clog2(ID_W),
    localparam int TMAX    = (PRES_GAP > PRES_CYC) ? PRES_GAP : PRES_CYC,
    localparam int TW      = $clog2(TMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    input  logic          long_low,
    input  logic          bit_valid,
    input  logic          bit_in,
    input  logic          id_eq,
    output owr_state_e    state,
    output logic [IW-1:0] idx
);
    typedef struct packed {
        owr_state_e       st;
        logic [TW-1:0]    tmr;
        logic [IW-1:0]    idx;
        logic [CMD_W-1:0] cmd;
    } fsm_t;

    fsm_t r_d, r_q;
    logic [CMD_W-1:0] cmd_next;

    assign cmd_next = {bit_in, r_q.cmd[CMD_W-1:1]};

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_RSTLOW: begin
                if (line_in) begin
                    r_d.st  = ST_GAP;
                    r_d.tmr = '0;
                end
            end
            ST_GAP: begin
                if (r_q.tmr == TW'(PRES_GAP - 1)) begin
                    r_d.st  = ST_PRES;
                    r_d.tmr = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_PRES: begin
                if (r_q.tmr == TW'(PRES_CYC - 1)) begin
                    r_d.st  = ST_CMD;
                    r_d.idx = '0;
                    r_d.cmd = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_CMD: begin
                if (bit_valid) begin
                    r_d.cmd = cmd_next;
                    if (r_q.idx == IW'(CMD_W - 1)) begin
                        r_d.idx = '0;
                        if (cmd_next == OP_READ_ID)       r_d.st = ST_SEND;
                        else if (cmd_next == OP_MATCH_ID) r_d.st = ST_MATCH;
                        else                              r_d.st = ST_SILENT;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (bit_valid) begin
                    if (r_q.idx == IW'(ID_W - 1)) r_d.st  = ST_SEL;
                    else                          r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_MATCH: begin
                if (bit_valid) begin
                    if (!id_eq)                        r_d.st  = ST_SILENT;
                    else if (r_q.idx == IW'(ID_W - 1)) r_d.st  = ST_SEL;
                    else                               r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: ;
        endcase
        // bus reset wins over every state
        if (long_low) begin
            r_d.st = ST_RSTLOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_SILENT;
            r_q.tmr <= '0;
            r_q.idx <= '0;
            r_q.cmd <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;
    assign idx   = r_q.idx;

endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
    import owr_rom_pkg::*;
#(
    parameter int              RST_CYC  = 6000,
    parameter int              PRES_GAP = 1000,
    parameter int              PRES_CYC = 4000,
    parameter int              ID_W     = 64,
    parameter logic [ID_W-1:0] ROM_ID   = 64'hA5123456789ABC2D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic bit_valid,
    input  logic bit_in,
    output logic tx_req,
    output logic tx_bit,
    output logic selected,
    output logic drv_n
);
    localparam int IW = $clog2(ID_W);

    logic          long_low;
    logic          id_eq;
    logic          ref_bit;
    owr_state_e    state;
    logic [IW-1:0] idx;

    owr_low_timer #(.RST_CYC(RST_CYC)) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .long_low (long_low)
    );

    owr_id_cmp #(.ID_W(ID_W), .ROM_ID(ROM_ID)) u_cmp (
        .idx     (idx),
        .bit_in  (bit_in),
        .ref_bit (ref_bit),
        .eq      (id_eq)
    );

    owr_rom_fsm #(.PRES_GAP(PRES_GAP), .PRES_CYC(PRES_CYC), .ID_W(ID_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .long_low  (long_low),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .id_eq     (id_eq),
        .state     (state),
        .idx       (idx)
    );

    assign tx_req   = (state == ST_SEND);
    assign tx_bit   = (state == ST_SEND) ? ref_bit : 1'b1;
    assign selected = (state == ST_SEL);
    assign drv_n    = (state != ST_PRES);

endmodule

// File: rtl/owr_rom_layer_chk.sv
module owr_rom_layer_chk #(
    parameter int RST_CYC = 6000
) (
    input logic clk,
    input logic rst_n,
    input logic line_in,
    input logic bit_valid,
    input logic tx_req,
    input logic selected,
    input logic drv_n
);
    localparam int LIM = RST_CYC + 2;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   low_q <= '0;
        else if (line_in)             low_q <= '0;
        else if (low_q != CW'(LIM))   low_q <= low_q + 1'b1;
    end

    // R2: a long low has abandoned every transaction
    a_r2_long_low_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q == CW'(LIM)) |-> (!selected && !tx_req && drv_n));

    // R3: presence only begins after the line was released
    a_r3_pres_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_n) |-> $past(line_in));

    // R5: read data starts only on a command strobe
    a_r5_tx_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(bit_valid));

    // R6: selection is earned by a strobed bit
    a_r6_sel_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> $past(bit_valid));

    // R9: presence pulse excludes data and selection
    a_r9_pres_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_n |-> (!tx_req && !selected));

    // R10: selection and read never overlap
    a_r10_sel_vs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !(selected && tx_req));

endmodule

bind owr_rom_layer owr_rom_layer_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .bit_valid (bit_valid),
    .tx_req    (tx_req),
    .selected  (selected),
    .drv_n     (drv_n)
);

// File: tb/sim_owr_rom_layer.sv
module sim_owr_rom_layer;
    localparam int          CLK_PER  = 10;
    localparam int          RST_CYC  = 40;
    localparam int          PRES_GAP = 3;
    localparam int          PRES_CYC = 12;
    localparam logic [63:0] ID       = 64'hA5123456789ABC2D;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [63:0] pat;
        logic        exp_sel;
    } vec_t;

    localparam vec_t [6:0] VECS = '{
        '{8'h55, ID,                         1'b1},
        '{8'h55, ID ^ 64'h1,                 1'b0},
        '{8'h55, ID ^ 64'h8000000000000000,  1'b0},
        '{8'h33, ID,                         1'b1},
        '{8'hF0, ID,                         1'b0},
        '{8'hAA, ID,                         1'b0},
        '{8'h55, ID ^ 64'h0000010000000000,  1'b0}
    };

    logic clk = 0, rst_n = 0, line_m = 1, bit_valid = 0, bit_in = 0;
    logic line_in, tx_req, tx_bit, selected, drv_n;
    int checks = 0, errors = 0;

    assign line_in = line_m & drv_n;  // wired-AND bus

    always #(CLK_PER/2) clk = ~clk;

    owr_rom_layer #(.RST_CYC(RST_CYC), .PRES_GAP(PRES_GAP), .PRES_CYC(PRES_CYC),
                    .ID_W(64), .ROM_ID(ID)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bit_valid(bit_valid),
        .bit_in(bit_in), .tx_req(tx_req), .tx_bit(tx_bit),
        .selected(selected), .drv_n(drv_n)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_in = b; bit_valid = 1;
        @(negedge clk); bit_valid = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic hold_low(input int n);
        @(negedge clk); line_m = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_reset(output int plen);
        hold_low(RST_CYC + 5);
        line_m = 1;
        plen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!drv_n) plen++;
            else if (plen > 0) break;
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        report();
        $finish;
    end

    initial begin
        int plen;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 selected", selected, 0);
        check("R1 tx_req", tx_req, 0);
        check("R1 drv_n", drv_n, 1);
        rst_n = 1;
        // R1/R4: no command taken before a bus reset
        send_byte(8'h33);
        check("R1 no cmd before reset", tx_req, 0);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(ID[i]);
        check("R4 no match before presence", selected, 0);

        // vector table
        foreach (VECS[v]) begin
            bus_reset(plen);
            check("R3 presence length", plen, PRES_CYC);
            send_byte(VECS[v].cmd);
            if (VECS[v].cmd == 8'h33) begin
                for (int i = 0; i < 64; i++) begin
                    check("R5 tx_req", tx_req, 1);
                    check("R5 tx_bit", tx_bit, ID[i]);
                    check("R9 drv_n idle", drv_n, 1);
                    send_bit(1'b1);
                end
            end else begin
                if (VECS[v].cmd != 8'h55)
                    check("R8 unknown code silent", tx_req, 0);
                for (int i = 0; i < 64; i++) send_bit(VECS[v].pat[i]);
            end
            check(VECS[v].cmd == 8'h55 ? "R6 match result" :
                  VECS[v].cmd == 8'h33 ? "R5 select after read" : "R8 unknown code",
                  selected, VECS[v].exp_sel);
            if (!VECS[v].exp_sel) begin
                send_byte(8'h33);
                check("R7 silent tx_req", tx_req, 0);
                for (int i = 0; i < 64; i++) send_bit(ID[i]);
                check("R7 silent selected", selected, 0);
            end
        end

        // R10: selected holds, bits ignored; R2: short low ignored
        bus_reset(plen);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(ID[i]);
        check("R6 selected", selected, 1);
        send_byte(8'h33);
        check("R10 bits ignored tx_req", tx_req, 0);
        check("R10 selected held", selected, 1);
        hold_low(5);
        line_m = 1;
        @(negedge clk);
        check("R2 short low ignored", selected, 1);
        check("R9 no presence on short low", drv_n, 1);

        // R2: long low aborts a read in progress
        bus_reset(plen);
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        check("R5 mid-read tx_req", tx_req, 1);
        hold_low(RST_CYC + 5);
        check("R2 abort tx_req", tx_req, 0);
        check("R2 abort selected", selected, 0);
        line_m = 1;
        plen = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!drv_n) plen++;
            else if (plen > 0) break;
        end
        check("R3 presence after abort", plen, PRES_CYC);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(ID[i]);
        check("R2 resume after abort", selected, 1);

        // R2: long low clears selection
        hold_low(RST_CYC + 5);
        check("R2 reset clears selected", selected, 0);
        line_m = 1;
        repeat (PRES_GAP + PRES_CYC + 5) @(negedge clk);

        report();
        $finish;
    end
endmodule